// File: doc/BRIEF.md
# Multi-Core Interrupt Routing Controller

This block collects thirty-two asynchronous interrupt request lines and conditions each one on its own. A line is first brought into the clock domain. It is then treated either as a level, active high or active low, or as a rising or falling edge that sets a sticky pending bit. A per-source enable gates the result. Each pending, enabled source is then steered to one of four parent interrupt outputs, and it becomes visible to any of four processor cores.

Software configures the block through a small register port. The port carries an address, write data, a write enable and a flag that selects a byte write or a word write. Read data is returned combinationally in the same cycle. Every source owns one routing byte. The upper nibble of that byte picks the parent output with a one-hot code, and the lower nibble lists the cores that may observe the source. A core-select input chooses which core's filtered pending bitmap the status register returns.

Top module: `irq_route_ctrl`

## Requirements
- R1: After a synchronous active-low reset every source is disabled and level-triggered, polarity is zero, every routing byte is zero, all parent outputs are low, and the status register (0x40) reads zero.
- R2: The routing byte of source n sits at byte offset n (0x00 to 0x1F). A byte write at offset n stores wdata[7:0] there. A word write at an aligned offset stores four bytes, with source 4m+j taking wdata[8j+7:8j]. A read at any offset below 0x20 returns the four bytes of the aligned word packed the same way.
- R3: A word write to 0x28 sets the enable of every source whose data bit is 1 and leaves every other enable alone. The enable bitmap reads back at 0x24, with bit n for source n.
- R4: A word write to 0x2C clears the enable of every source whose data bit is 1, so writing all ones disables every source. Zero bits leave their enables alone.
- R5: A source in level mode (edge bit 0) is pending while its synchronised input equals the active level: high for polarity 0, low for polarity 1. The pending state appears in the status register two clock edges after the input changes.
- R6: A source in edge mode (edge bit 1) latches pending on a rising input edge when its polarity is 0, and on a falling edge when its polarity is 1. The latched bit is visible three clock edges after the input edge and stays set after the input returns. An edge of the other direction latches nothing.
- R7: An edge-mode latched bit clears in the cycle of a word write to 0x2C with that source's bit set. It also clears in the cycle of a word write to 0x28 with that source's bit set, even when the source is already enabled.
- R8: Parent output k is a register that holds the OR of all enabled, pending sources whose routing byte bit 4+k is 1. It follows a level input three clock edges after the input changes. A source whose routing byte has no bit set in [7:4] drives no parent output.
- R9: A read of 0x40 returns a 32-bit bitmap of the sources that are enabled, pending, and have bit core_sel set in their routing byte.
- R10: Reads from any offset other than 0x00–0x1F, 0x24, 0x30, 0x34 and 0x40 return zero; this includes the write-only 0x28 and 0x2C. Writes to unmapped offsets, to 0x24 or 0x40, and byte writes to offsets from 0x20 upward change no state.
- R11: The polarity bitmap is a read/write word at 0x30, and the edge-mode bitmap is a read/write word at 0x34.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 32 | Asynchronous interrupt request lines, bit n is source n |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_byte | input | 1 | 1 = byte write of wdata[7:0], 0 = word write |
| core_sel | input | 2 | Core whose view the status register returns |
| rdata | output | 32 | Combinational read data for addr |
| parent_irq | output | 4 | Registered parent interrupt outputs |

## Verification
The timing of each result is counted from the clock edge that captures the stimulus. A register write takes effect on its own edge. A level input reaches the status read after two edges and a parent output after three. An edge input reaches the status read after three edges and a parent output after four. Inputs change on the falling clock edge. Each check samples at the falling edge after exactly that many rising edges, and it also checks one edge early where the count matters, so a stage that is added or removed shows up as a mismatch.

// File: rtl/irq_route_pkg.sv
// Package: irq_route_pkg
// Shared register offsets and the trigger-mode encoding for the routing
// controller. Assumes an 8-bit byte address and a 32-bit data word.
package irq_route_pkg;

    localparam int unsigned ADDR_W = 8;
    localparam int unsigned DATA_W = 32;

    // Word register offsets; the routing bytes occupy 0x00 upward.
    localparam logic [ADDR_W-1:0] OFS_EN_RD  = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_EN_SET = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_EN_CLR = 8'h2C;
    localparam logic [ADDR_W-1:0] OFS_POL    = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_EDGE   = 8'h34;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 8'h40;

    // Trigger mode as {edge bit, polarity bit}.
    typedef enum logic [1:0] {
        TRIG_LVL_HIGH = 2'b00,
        TRIG_LVL_LOW  = 2'b01,
        TRIG_RISE     = 2'b10,
        TRIG_FALL     = 2'b11
    } trig_mode_e;

endpackage

// File: rtl/irq_route_regs.sv
// Module: irq_route_regs
// Register file and address decode. Holds the routing bytes and the enable,
// polarity and edge bitmaps, produces per-source latch-clear pulses on
// enable writes, and returns combinational read data.
// Assumes NUM_SRC <= 32 and ROUTE_W == 8 (one byte per source).
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned ROUTE_W = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [DATA_W-1:0]                wdata,
    input  logic                             wr_en,
    input  logic                             wr_byte,
    input  logic [NUM_SRC-1:0]               core_view,
    output logic [NUM_SRC-1:0]               src_en,
    output logic [NUM_SRC-1:0]               src_pol,
    output logic [NUM_SRC-1:0]               src_edge,
    output logic [NUM_SRC-1:0][ROUTE_W-1:0]  route,
    output logic [NUM_SRC-1:0]               latch_clr,
    output logic [DATA_W-1:0]                rdata
);

    localparam int unsigned BYTES_PER_WORD = DATA_W / 8;
    localparam logic [ADDR_W-1:0] ROUTE_END = ADDR_W'(NUM_SRC);

    logic                               word_wr;
    logic                               byte_wr;
    logic                               in_route;
    logic [NUM_SRC-1:0]                 set_mask;
    logic [NUM_SRC-1:0]                 clr_mask;
    logic [NUM_SRC-1:0][ROUTE_W-1:0]    route_d;

    // Classify the current access.
    always_comb begin
        word_wr  = wr_en && !wr_byte;
        byte_wr  = wr_en &&  wr_byte;
        in_route = (addr < ROUTE_END);
        set_mask = (word_wr && addr == OFS_EN_SET) ? wdata[NUM_SRC-1:0] : '0;
        clr_mask = (word_wr && addr == OFS_EN_CLR) ? wdata[NUM_SRC-1:0] : '0;
    end

    // Any enable-register write touching a source clears its edge latch.
    assign latch_clr = set_mask | clr_mask;

    // Next value of every routing byte for byte and word writes.
    always_comb begin
        route_d = route;
        for (int n = 0; n < NUM_SRC; n++) begin
            if (byte_wr && in_route && addr == ADDR_W'(n)) begin
                route_d[n] = wdata[ROUTE_W-1:0];
            end else if (word_wr && in_route &&
                         addr[ADDR_W-1:2] == (ADDR_W-2)'(n / BYTES_PER_WORD)) begin
                route_d[n] = wdata[8*(n % BYTES_PER_WORD) +: ROUTE_W];
            end
        end
    end

    // Register update for routing, enables, polarity and edge mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route    <= '0;
            src_en   <= '0;
            src_pol  <= '0;
            src_edge <= '0;
        end else begin
            route  <= route_d;
            src_en <= (src_en | set_mask) & ~clr_mask;
            if (word_wr && addr == OFS_POL) begin
                src_pol <= wdata[NUM_SRC-1:0];
            end
            if (word_wr && addr == OFS_EDGE) begin
                src_edge <= wdata[NUM_SRC-1:0];
            end
        end
    end

    // Combinational read mux; unmapped offsets return zero.
    always_comb begin
        rdata = '0;
        if (in_route) begin
            for (int j = 0; j < int'(BYTES_PER_WORD); j++) begin
                if (int'(addr[ADDR_W-1:2]) * int'(BYTES_PER_WORD) + j < int'(NUM_SRC)) begin
                    rdata[8*j +: 8] =
                        8'(route[int'(addr[ADDR_W-1:2]) * int'(BYTES_PER_WORD) + j]);
                end
            end
        end else begin
            case (addr)
                OFS_EN_RD: rdata = DATA_W'(src_en);
                OFS_POL:   rdata = DATA_W'(src_pol);
                OFS_EDGE:  rdata = DATA_W'(src_edge);
                OFS_STAT:  rdata = DATA_W'(core_view);
                default:   rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/irq_route_cond.sv
// Module: irq_route_cond
// Per-source input conditioning: a multi-flop synchroniser, a one-flop
// history for edge detection, a sticky edge latch and level handling.
// Assumes SYNC_STAGES >= 2. The edge latch is held at zero while the
// source is in level mode, so entering edge mode starts clean.
module irq_route_cond
    import irq_route_pkg::*;
#(
    parameter int unsigned NUM_SRC     = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic [NUM_SRC-1:0] src_pol,
    input  logic [NUM_SRC-1:0] src_edge,
    input  logic [NUM_SRC-1:0] latch_clr,
    output logic [NUM_SRC-1:0] src_pend
);

    for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
        logic [SYNC_STAGES-1:0] chain;
        logic                   sampled;
        logic                   hist;
        logic                   edge_hit;
        logic                   latched;
        trig_mode_e             mode;

        assign sampled = chain[SYNC_STAGES-1];
        assign mode    = trig_mode_e'({src_edge[n], src_pol[n]});

        // Bring the raw line into the clock domain and keep one sample of history.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= '0;
                hist  <= 1'b0;
            end else begin
                chain <= {chain[SYNC_STAGES-2:0], irq_in[n]};
                hist  <= sampled;
            end
        end

        // Detect the edge direction that the polarity selects.
        always_comb begin
            edge_hit = 1'b0;
            if (mode == TRIG_RISE) edge_hit = sampled && !hist;
            if (mode == TRIG_FALL) edge_hit = !sampled && hist;
        end

        // Sticky edge latch; an enable write clears it and wins over a new edge.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                latched <= 1'b0;
            end else if (latch_clr[n] || !src_edge[n]) begin
                latched <= 1'b0;
            end else if (edge_hit) begin
                latched <= 1'b1;
            end
        end

        // Pending: the latch in edge mode, the polarity-corrected level otherwise.
        always_comb begin
            case (mode)
                TRIG_LVL_HIGH: src_pend[n] = sampled;
                TRIG_LVL_LOW:  src_pend[n] = !sampled;
                default:       src_pend[n] = latched;
            endcase
        end
    end

endmodule

// File: rtl/irq_route_steer.sv
// Module: irq_route_steer
// Gates pending sources with their enables, ORs them onto the parent
// outputs selected by the upper routing bits (registered), and forms the
// per-core pending view selected by core_sel (combinational).
// Assumes routing byte layout {parent one-hot [NUM_PARENT], core mask [NUM_CORE]}.
module irq_route_steer #(
    parameter int unsigned NUM_SRC    = 32,
    parameter int unsigned NUM_PARENT = 4,
    parameter int unsigned NUM_CORE   = 4,
    parameter int unsigned ROUTE_W    = NUM_PARENT + NUM_CORE,
    parameter int unsigned CORE_W     = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_SRC-1:0]              src_pend,
    input  logic [NUM_SRC-1:0]              src_en,
    input  logic [NUM_SRC-1:0][ROUTE_W-1:0] route,
    input  logic [CORE_W-1:0]               core_sel,
    output logic [NUM_PARENT-1:0]           parent_irq,
    output logic [NUM_SRC-1:0]              core_view
);

    logic [NUM_SRC-1:0]    eff;
    logic [NUM_PARENT-1:0] parent_d;

    assign eff = src_pend & src_en;

    // Collect each parent line from the sources that name it.
    always_comb begin
        parent_d = '0;
        for (int n = 0; n < NUM_SRC; n++) begin
            for (int k = 0; k < NUM_PARENT; k++) begin
                if (eff[n] && route[n][NUM_CORE + k]) parent_d[k] = 1'b1;
            end
        end
    end

    // Register the parent outputs so they leave the block glitch-free.
    always_ff @(posedge clk) begin
        if (!rst_n) parent_irq <= '0;
        else        parent_irq <= parent_d;
    end

    // Filter the enabled pending set by the selected core's routing bit.
    for (genvar n = 0; n < NUM_SRC; n++) begin : g_view
        assign core_view[n] = eff[n] && route[n][core_sel];
    end

endmodule

// File: rtl/irq_route_ctrl.sv
// Module: irq_route_ctrl (top)
// Multi-core interrupt routing controller: register file, per-source
// conditioning and steering to parent outputs and per-core views.
// Assumes a single clock domain for the register port; irq_in is asynchronous.
module irq_route_ctrl
    import irq_route_pkg::*;
#(
    parameter int unsigned NUM_SRC     = 32,
    parameter int unsigned NUM_PARENT  = 4,
    parameter int unsigned NUM_CORE    = 4,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned ROUTE_W    = NUM_PARENT + NUM_CORE,
    localparam int unsigned CORE_W     = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_SRC-1:0]    irq_in,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic                  wr_en,
    input  logic                  wr_byte,
    input  logic [CORE_W-1:0]     core_sel,
    output logic [DATA_W-1:0]     rdata,
    output logic [NUM_PARENT-1:0] parent_irq
);

    logic [NUM_SRC-1:0]              src_en;
    logic [NUM_SRC-1:0]              src_pol;
    logic [NUM_SRC-1:0]              src_edge;
    logic [NUM_SRC-1:0]              src_pend;
    logic [NUM_SRC-1:0]              latch_clr;
    logic [NUM_SRC-1:0]              core_view;
    logic [NUM_SRC-1:0][ROUTE_W-1:0] route;

    irq_route_regs #(
        .NUM_SRC (NUM_SRC),
        .ROUTE_W (ROUTE_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .wdata     (wdata),
        .wr_en     (wr_en),
        .wr_byte   (wr_byte),
        .core_view (core_view),
        .src_en    (src_en),
        .src_pol   (src_pol),
        .src_edge  (src_edge),
        .route     (route),
        .latch_clr (latch_clr),
        .rdata     (rdata)
    );

    irq_route_cond #(
        .NUM_SRC     (NUM_SRC),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .src_pol   (src_pol),
        .src_edge  (src_edge),
        .latch_clr (latch_clr),
        .src_pend  (src_pend)
    );

    irq_route_steer #(
        .NUM_SRC    (NUM_SRC),
        .NUM_PARENT (NUM_PARENT),
        .NUM_CORE   (NUM_CORE),
        .ROUTE_W    (ROUTE_W),
        .CORE_W     (CORE_W)
    ) u_steer (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_pend   (src_pend),
        .src_en     (src_en),
        .route      (route),
        .core_sel   (core_sel),
        .parent_irq (parent_irq),
        .core_view  (core_view)
    );

endmodule

// File: rtl/irq_route_ctrl_chk.sv
// Module: irq_route_ctrl_chk
// Property checker bound to irq_route_ctrl. It observes the register port,
// the parent outputs and the internal enable and pending bitmaps.
module irq_route_ctrl_chk
    import irq_route_pkg::*;
#(
    parameter int unsigned NUM_SRC    = 32,
    parameter int unsigned NUM_PARENT = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [ADDR_W-1:0]     addr,
    input logic [DATA_W-1:0]     wdata,
    input logic                  wr_en,
    input logic                  wr_byte,
    input logic [DATA_W-1:0]     rdata,
    input logic [NUM_PARENT-1:0] parent_irq,
    input logic [NUM_SRC-1:0]    src_en,
    input logic [NUM_SRC-1:0]    src_pend
);

    logic en_write;
    logic mapped;

    // Decode, on the checker's side, which accesses touch the enables and which offsets are mapped.
    always_comb begin
        en_write = wr_en && !wr_byte && (addr == OFS_EN_SET || addr == OFS_EN_CLR);
        mapped   = (addr < ADDR_W'(NUM_SRC)) || addr == OFS_EN_RD || addr == OFS_POL ||
                   addr == OFS_EDGE || addr == OFS_STAT;
    end

    // R1: reset leaves outputs and enables cleared
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (parent_irq == '0 && src_en == '0));

    // R3: every 1 written to the set register is enabled next cycle
    a_r3_set_applies: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_byte && addr == OFS_EN_SET)
        |=> ((src_en & $past(wdata[NUM_SRC-1:0])) == $past(wdata[NUM_SRC-1:0])));

    // R4: every 1 written to the clear register is disabled next cycle
    a_r4_clear_applies: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_byte && addr == OFS_EN_CLR)
        |=> ((src_en & $past(wdata[NUM_SRC-1:0])) == '0));

    // R3 / R4: enables move only on enable-register writes
    a_r4_enable_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !en_write |=> $stable(src_en));

    // R8: a parent output is high only if some enabled source was pending
    a_r8_parent_source: assert property (@(posedge clk) disable iff (!rst_n)
        (|parent_irq) |-> $past(|(src_en & src_pend)));

    // R9: status never shows a disabled source
    a_r9_status_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == OFS_STAT) |-> ((rdata & ~DATA_W'(src_en)) == '0));

    // R10: unmapped offsets read as zero
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> (rdata == '0));

endmodule

bind irq_route_ctrl irq_route_ctrl_chk #(
    .NUM_SRC    (NUM_SRC),
    .NUM_PARENT (NUM_PARENT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .wdata      (wdata),
    .wr_en      (wr_en),
    .wr_byte    (wr_byte),
    .rdata      (rdata),
    .parent_irq (parent_irq),
    .src_en     (src_en),
    .src_pend   (src_pend)
);

// File: tb/irq_route_ctrl_tb.sv
// Directed bench for irq_route_ctrl: one task per scenario, each checking
// its own results at the falling edge after the expected number of rising edges.
module irq_route_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wr_en = 1'b0;
    logic        wr_byte = 1'b0;
    logic [1:0]  core_sel = '0;
    logic [31:0] rdata;
    logic [3:0]  parent_irq;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    irq_route_ctrl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_in     (irq_in),
        .addr       (addr),
        .wdata      (wdata),
        .wr_en      (wr_en),
        .wr_byte    (wr_byte),
        .core_sel   (core_sel),
        .rdata      (rdata),
        .parent_irq (parent_irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic bw);
        addr = a; wdata = d; wr_byte = bw; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wr_byte = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic cleanup();
        wr(8'h2C, 32'hFFFF_FFFF, 1'b0);
        wr(8'h30, 32'h0, 1'b0);
        wr(8'h34, 32'h0, 1'b0);
        irq_in = '0;
        core_sel = 2'd0;
        step(3);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(8'h24, d); check("R1 enables after reset", d, 32'h0);
        rd(8'h30, d); check("R1 polarity after reset", d, 32'h0);
        rd(8'h34, d); check("R1 edge after reset", d, 32'h0);
        rd(8'h40, d); check("R1 status after reset", d, 32'h0);
        rd(8'h1C, d); check("R1 routing after reset", d, 32'h0);
        check("R1 parent after reset", 32'(parent_irq), 32'h0);
    endtask

    task automatic t_route_rw();
        logic [31:0] d;
        wr(8'h05, 32'hFFFF_FF12, 1'b1);
        rd(8'h04, d); check("R2 byte write lane 1", d, 32'h0000_1200);
        wr(8'h08, 32'h4433_2211, 1'b0);
        rd(8'h08, d); check("R2 word write", d, 32'h4433_2211);
        rd(8'h04, d); check("R2 neighbour word untouched", d, 32'h0000_1200);
        wr(8'h0B, 32'h0000_0099, 1'b1);
        rd(8'h0A, d); check("R2 byte write lane 3 read unaligned", d, 32'h9933_2211);
        wr(8'h08, 32'h0, 1'b0);
        wr(8'h04, 32'h0, 1'b0);
    endtask

    task automatic t_enable();
        logic [31:0] d;
        wr(8'h28, 32'h0000_00F0, 1'b0);
        rd(8'h24, d); check("R3 set bits", d, 32'h0000_00F0);
        wr(8'h28, 32'h0000_000F, 1'b0);
        rd(8'h24, d); check("R3 zero bits keep enables", d, 32'h0000_00FF);
        wr(8'h2C, 32'h0000_0030, 1'b0);
        rd(8'h24, d); check("R4 clear bits", d, 32'h0000_00CF);
        wr(8'h2C, 32'hFFFF_FFFF, 1'b0);
        rd(8'h24, d); check("R4 clear all", d, 32'h0);
    endtask

    task automatic t_cfg_rw();
        logic [31:0] d;
        wr(8'h30, 32'hA5A5_0001, 1'b0);
        rd(8'h30, d); check("R11 polarity readback", d, 32'hA5A5_0001);
        wr(8'h34, 32'h0000_F00F, 1'b0);
        rd(8'h34, d); check("R11 edge readback", d, 32'h0000_F00F);
        cleanup();
    endtask

    task automatic t_level_high();
        logic [31:0] d;
        wr(8'h03, 32'h11, 1'b1);
        wr(8'h28, 32'h8, 1'b0);
        irq_in[3] = 1'b1;
        step(1);
        rd(8'h40, d); check("R5 level high not yet after one edge", d, 32'h0);
        step(1);
        rd(8'h40, d); check("R5 level high after two edges", d, 32'h8);
        check("R8 parent not yet after two edges", 32'(parent_irq), 32'h0);
        step(1);
        check("R8 parent0 after three edges", 32'(parent_irq), 32'h1);
        irq_in[3] = 1'b0;
        step(2);
        rd(8'h40, d); check("R5 level high released", d, 32'h0);
        check("R8 parent holds one more edge", 32'(parent_irq), 32'h1);
        step(1);
        check("R8 parent0 released", 32'(parent_irq), 32'h0);
        cleanup();
    endtask

    task automatic t_level_low();
        logic [31:0] d;
        wr(8'h07, 32'h21, 1'b1);
        wr(8'h30, 32'h80, 1'b0);
        wr(8'h28, 32'h80, 1'b0);
        rd(8'h40, d); check("R5 level low pending on low input", d, 32'h80);
        step(1);
        check("R8 parent1 from level low", 32'(parent_irq), 32'h2);
        irq_in[7] = 1'b1;
        step(2);
        rd(8'h40, d); check("R5 level low released by high input", d, 32'h0);
        cleanup();
    endtask

    task automatic t_rise();
        logic [31:0] d;
        wr(8'h0A, 32'h41, 1'b1);
        wr(8'h34, 32'h400, 1'b0);
        wr(8'h28, 32'h400, 1'b0);
        irq_in[10] = 1'b1;
        step(1);
        irq_in[10] = 1'b0;
        step(1);
        rd(8'h40, d); check("R6 rise not latched after two edges", d, 32'h0);
        step(1);
        rd(8'h40, d); check("R6 rise latched after three edges", d, 32'h400);
        step(1);
        check("R8 parent2 from edge source", 32'(parent_irq), 32'h4);
        step(5);
        rd(8'h40, d); check("R6 latch holds after input low", d, 32'h400);
        wr(8'h2C, 32'h400, 1'b0);
        rd(8'h40, d); check("R7 disable clears latch", d, 32'h0);
        wr(8'h28, 32'h400, 1'b0);
        rd(8'h40, d); check("R7 re-enable finds latch cleared", d, 32'h0);
        irq_in[10] = 1'b1;
        step(1);
        irq_in[10] = 1'b0;
        step(2);
        rd(8'h40, d); check("R6 second rise latched", d, 32'h400);
        wr(8'h28, 32'h400, 1'b0);
        rd(8'h40, d); check("R7 enable write clears latch while enabled", d, 32'h0);
        cleanup();
    endtask

    task automatic t_fall();
        logic [31:0] d;
        wr(8'h0C, 32'h81, 1'b1);
        wr(8'h34, 32'h1000, 1'b0);
        wr(8'h30, 32'h1000, 1'b0);
        wr(8'h28, 32'h1000, 1'b0);
        irq_in[12] = 1'b1;
        step(4);
        rd(8'h40, d); check("R6 falling mode ignores rise", d, 32'h0);
        irq_in[12] = 1'b0;
        step(2);
        rd(8'h40, d); check("R6 fall not latched after two edges", d, 32'h0);
        step(1);
        rd(8'h40, d); check("R6 fall latched after three edges", d, 32'h1000);
        step(1);
        check("R8 parent3 from falling source", 32'(parent_irq), 32'h8);
        cleanup();
    endtask

    task automatic t_core_view();
        logic [31:0] d;
        wr(8'h03, 32'h14, 1'b1);
        wr(8'h05, 32'h1C, 1'b1);
        wr(8'h28, 32'h8, 1'b0);
        irq_in[3] = 1'b1;
        irq_in[5] = 1'b1;
        step(2);
        core_sel = 2'd0;
        rd(8'h40, d); check("R9 core0 excluded", d, 32'h0);
        core_sel = 2'd2;
        rd(8'h40, d); check("R9 core2 sees source 3", d, 32'h8);
        core_sel = 2'd3;
        rd(8'h40, d); check("R9 disabled source hidden from core3", d, 32'h0);
        wr(8'h28, 32'h20, 1'b0);
        rd(8'h40, d); check("R9 core3 sees enabled source 5", d, 32'h20);
        core_sel = 2'd2;
        rd(8'h40, d); check("R9 core2 sees both", d, 32'h28);
        wr(8'h03, 32'h0, 1'b1);
        wr(8'h05, 32'h0, 1'b1);
        cleanup();
    endtask

    task automatic t_no_parent();
        logic [31:0] d;
        wr(8'h14, 32'h01, 1'b1);
        wr(8'h28, 32'h0010_0000, 1'b0);
        irq_in[20] = 1'b1;
        step(3);
        rd(8'h40, d); check("R8 unrouted source still pending", d, 32'h0010_0000);
        check("R8 no parent bit drives nothing", 32'(parent_irq), 32'h0);
        wr(8'h14, 32'h0, 1'b1);
        cleanup();
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        wr(8'h00, 32'h0403_0201, 1'b0);
        wr(8'h30, 32'h0000_000F, 1'b0);
        wr(8'h30, 32'h0000_00FF, 1'b1);
        rd(8'h30, d); check("R10 byte write to word register ignored", d, 32'h0000_000F);
        wr(8'h24, 32'h0000_FFFF, 1'b0);
        rd(8'h24, d); check("R10 write to enable readback ignored", d, 32'h0);
        wr(8'h38, 32'hFFFF_FFFF, 1'b0);
        wr(8'h40, 32'hFFFF_FFFF, 1'b0);
        wr(8'h80, 32'hFFFF_FFFF, 1'b0);
        rd(8'h00, d); check("R10 stray writes leave routing", d, 32'h0403_0201);
        rd(8'h24, d); check("R10 stray writes leave enables", d, 32'h0);
        rd(8'h38, d); check("R10 unmapped read 0x38", d, 32'h0);
        rd(8'h28, d); check("R10 write-only set reads zero", d, 32'h0);
        rd(8'h2C, d); check("R10 write-only clear reads zero", d, 32'h0);
        rd(8'h21, d); check("R10 unmapped read 0x21", d, 32'h0);
        rd(8'h80, d); check("R10 unmapped read 0x80", d, 32'h0);
        wr(8'h00, 32'h0, 1'b0);
        cleanup();
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_route_rw();
        t_enable();
        t_cfg_rw();
        t_level_high();
        t_level_low();
        t_rise();
        t_fall();
        t_core_view();
        t_no_parent();
        t_unmapped();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule